// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Forcing

This block turns bytes written by a bus master into asynchronous serial frames. Each frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit and one or two high stop bits. The bit rate comes from an external enable pulse, `tick16`, running at sixteen times the bit rate. Every bit lasts sixteen of those pulses. Divisor generation and register decode sit outside the block, so frame settings, mode bits and the break bit arrive as plain level inputs.

Bytes enter through a valid/ready write port. A byte is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly when the store is full. A byte offered while `wr_ready` is low is not taken, and the stored bytes stay as they were. With queueing enabled the store holds 16 bytes. With queueing disabled it acts as a single holding register. Once a frame has started, the shifter holds its own copy of the byte, so one more byte can wait behind it.

Three status outputs are kept separate. `tx_full` reports that the store is full. `tx_empty` reports that the store holds no byte, even while a frame is still on the line. `tx_busy` stays high until the last stop bit has ended. A maskable interrupt asks for more data. A break input drives the line low regardless of the shifter.

Top module: `serial_tx_top`

## Requirements
- R1: After reset `txd` is 1, `tx_busy` is 0, `tx_empty` is 1, `tx_full` is 0 and `wr_ready` is 1. Whenever the line is not in break and no frame is on it, `txd` is 1.
- R2: A frame starts with one 0 bit. The data bits follow, least significant first. Their count is 5 + `word_len` (`word_len` 0 gives 5 bits, 3 gives 8 bits). Each bit lasts 16 `tick16` pulses.
- R3: When `parity_on` is 1, one parity bit follows the data. If `parity_even` is 1, the number of ones in the data and parity bits together is even. If it is 0, that number is odd. When `parity_on` is 0, no parity bit is sent.
- R4: One stop bit of value 1 ends the frame, or two when `two_stop` is 1. `tx_busy` rises with the start bit and falls only after the final stop bit has ended. It is therefore high for exactly 16 × (frame bit count) `tick16` pulses.
- R5: Bytes go out in the order they were accepted. The store holds 16 bytes when `queue_on` is 1 and 1 byte when it is 0. `tx_full` is 1 exactly when the store is at that capacity.
- R6: `wr_ready` equals the inverse of `tx_full`. A write offered while the store is full is dropped, and neither the stored bytes nor their order change.
- R7: `tx_empty` is 1 exactly when the store holds no byte. It does not depend on a frame that is still being shifted out.
- R8: `tx_irq` = `irq_on` AND (store count ≤ 8 when `queue_on` is 1, or store count = 0 when `queue_on` is 0).
- R9: While `brk` is 1, `txd` is 0 whatever the shifter is doing, and the shifter keeps its own timing. After `brk` returns to 0, `txd` again follows the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16× the bit rate |
| queue_on | input | 1 | 1: 16-entry store, 0: single holding register |
| word_len | input | 2 | Data bits minus 5 |
| parity_on | input | 1 | Append a parity bit |
| parity_even | input | 1 | 1: even parity, 0: odd parity |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| brk | input | 1 | Force the line low |
| irq_on | input | 1 | Transmit interrupt mask (1 = enabled) |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Store can accept a byte |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial line output |
| tx_full | output | 1 | Store is at capacity |
| tx_empty | output | 1 | Store holds no byte |
| tx_busy | output | 1 | Frame in progress, including its last stop bit |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The hardest state to reach is a full 16-entry store with a write offered to it. The shifter takes the first byte straight away, so the store only fills once 17 bytes have been written. The bench holds `tick16` low while writing, so no frame can complete, and it checks the interrupt level after every write. It then offers an 18th byte, releases the ticks and decodes all 17 frames, confirming that the dropped byte never appears. A second hard case is `tx_empty` high while `tx_busy` is still high. The bench catches it by sampling in the middle of a lone frame. Every frame format (all word lengths, parity modes and stop counts) is decoded bit by bit against values computed in the bench.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic [2:0] {
    SH_IDLE  = 3'd0,
    SH_START = 3'd1,
    SH_DATA  = 3'd2,
    SH_PAR   = 3'd3,
    SH_STOP  = 3'd4
  } sh_state_t;

  typedef struct packed {
    logic [1:0] word_len;
    logic       parity_on;
    logic       two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/serial_tx_store.sv
module serial_tx_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              queue_on,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr, rptr;
  logic [CW-1:0]     cap;
  logic              push;

  assign cap   = queue_on ? CW'(DEPTH) : CW'(1);
  assign full  = (count >= cap);
  assign empty = (count == '0);
  assign push  = push_req && !full;
  assign head  = mem[rptr];

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop)  rptr <= ptr_next(rptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/serial_tx_parity.sv
module serial_tx_parity #(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        word_len,
  input  logic              parity_even,
  output logic              parity_bit
);
  logic [DATA_W-1:0] used;
  int unsigned       nbits;

  always_comb begin
    nbits = MIN_BITS + int'(word_len);
    for (int i = 0; i < DATA_W; i++) begin
      used[i] = data[i] && (i < nbits);
    end
    parity_bit = (^used) ^ !parity_even;
  end
endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter
  import serial_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5,
  parameter int TPB      = 16,
  localparam int IW = $clog2(DATA_W),
  localparam int TW = $clog2(TPB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              have_data,
  input  logic [DATA_W-1:0] head,
  input  logic              head_parity,
  input  frame_cfg_t        cfg,
  output logic              pop,
  output logic              line,
  output logic              busy
);
  sh_state_t         state;
  logic [TW-1:0]     tcnt;
  logic [IW-1:0]     bidx, last_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit, par_use, stop2, stop_idx;
  logic              bit_done;

  assign bit_done = tick16 && (tcnt == TW'(TPB - 1));
  assign pop      = (state == SH_IDLE) && have_data;
  assign busy     = (state != SH_IDLE);

  always_comb begin
    unique case (state)
      SH_START: line = 1'b0;
      SH_DATA:  line = shreg[0];
      SH_PAR:   line = par_bit;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      last_idx <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      par_use  <= 1'b0;
      stop2    <= 1'b0;
      stop_idx <= 1'b0;
    end else if (state == SH_IDLE) begin
      tcnt <= '0;
      if (have_data) begin
        state    <= SH_START;
        shreg    <= head;
        par_bit  <= head_parity;
        par_use  <= cfg.parity_on;
        stop2    <= cfg.two_stop;
        last_idx <= IW'(MIN_BITS - 1) + IW'(cfg.word_len);
      end
    end else begin
      if (tick16) tcnt <= bit_done ? '0 : tcnt + TW'(1);
      if (bit_done) begin
        unique case (state)
          SH_START: begin
            state <= SH_DATA;
            bidx  <= '0;
          end
          SH_DATA: begin
            shreg <= shreg >> 1;
            if (bidx == last_idx) begin
              state    <= par_use ? SH_PAR : SH_STOP;
              stop_idx <= 1'b0;
            end else begin
              bidx <= bidx + IW'(1);
            end
          end
          SH_PAR: begin
            state    <= SH_STOP;
            stop_idx <= 1'b0;
          end
          SH_STOP: begin
            if (stop2 && !stop_idx) stop_idx <= 1'b1;
            else                    state    <= SH_IDLE;
          end
          default: state <= SH_IDLE;
        endcase
      end
    end
  end

  // R4
  busy_end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(state) == SH_STOP && $past(bit_done));
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line);
endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top
  import serial_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 16,
  parameter int TPB       = 16,
  parameter int MIN_BITS  = 5,
  parameter int IRQ_LEVEL = DEPTH / 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              queue_on,
  input  logic [1:0]        word_len,
  input  logic              parity_on,
  input  logic              parity_even,
  input  logic              two_stop,
  input  logic              brk,
  input  logic              irq_on,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_full,
  output logic              tx_empty,
  output logic              tx_busy,
  output logic              tx_irq
);
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     count;
  logic              pop, line, head_par, store_empty;
  frame_cfg_t        cfg;

  assign cfg = '{word_len: word_len, parity_on: parity_on, two_stop: two_stop};

  serial_tx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .queue_on(queue_on),
    .push_req(wr_valid), .push_data(wr_data), .pop(pop),
    .head(head), .count(count), .full(tx_full), .empty(store_empty)
  );

  serial_tx_parity #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_par (
    .data(head), .word_len(word_len), .parity_even(parity_even),
    .parity_bit(head_par)
  );

  serial_tx_shifter #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS), .TPB(TPB)) u_sh (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .have_data(!store_empty),
    .head(head), .head_parity(head_par), .cfg(cfg),
    .pop(pop), .line(line), .busy(tx_busy)
  );

  assign wr_ready = !tx_full;
  assign tx_empty = store_empty;
  assign txd      = brk ? 1'b0 : line;
  assign tx_irq   = irq_on && (queue_on ? (count <= CW'(IRQ_LEVEL)) : store_empty);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !brk) |-> txd);
  // R9
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk) |-> !txd);
endmodule

// File: tb/test_serial_tx_top.sv
module test_serial_tx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0, queue_on = 1'b1, parity_on = 1'b0, parity_even = 1'b0;
  logic two_stop = 1'b0, brk = 1'b0, irq_on = 1'b1, wr_valid = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic [7:0] wr_data = '0;
  logic wr_ready, txd, tx_full, tx_empty, tx_busy, tx_irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_tx_top i_serial_tx_top (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .queue_on(queue_on),
    .word_len(word_len), .parity_on(parity_on), .parity_even(parity_even),
    .two_stop(two_stop), .brk(brk), .irq_on(irq_on), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .txd(txd), .tx_full(tx_full),
    .tx_empty(tx_empty), .tx_busy(tx_busy), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(posedge clk);
    #1 wr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // decode one frame from txd; tick16 must be 1 every cycle
  task automatic recv(input logic [7:0] d, input bit lone);
    int nb, cnt, guard;
    logic [15:0] smp, exp;
    int nd;
    logic [7:0] m;
    nd = 5 + int'(word_len);
    nb = 1 + nd + int'(parity_on) + 1 + int'(two_stop);
    guard = 0;
    while (txd !== 1'b0 && guard < 1000) begin @(negedge clk); guard++; end
    cnt = 0; smp = '0;
    while (tx_busy && cnt < 400) begin
      cnt++;
      if (cnt % 16 == 8) smp[cnt/16] = txd;
      if (lone && cnt == 24) begin
        check("R7 empty while busy", int'(tx_empty), 1);
        check("R7 busy mid-frame", int'(tx_busy), 1);
      end
      @(negedge clk);
    end
    m = 8'hFF >> (8 - nd);
    exp = '1;
    exp[0] = 1'b0;
    for (int i = 0; i < nd; i++) exp[1+i] = d[i];
    if (parity_on)
      exp[1+nd] = ($countones(d & m) % 2 == 1) ^ !parity_even;
    check($sformatf("R4 busy length d=%0h", d), cnt, nb * 16);
    check($sformatf("R2 R3 R4 frame bits d=%0h", d),
          int'(smp & ((16'h1 << nb) - 16'h1)), int'(exp & ((16'h1 << nb) - 16'h1)));
    check("R1 idle line high", int'(txd), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 txd", int'(txd), 1);
    check("R1 busy", int'(tx_busy), 0);
    check("R1 empty", int'(tx_empty), 1);
    check("R1 full", int'(tx_full), 0);
    check("R1 ready", int'(wr_ready), 1);
    check("R8 irq reset", int'(tx_irq), 1);

    // R2 R3 R4 sweep over every frame format
    tick16 = 1'b1;
    for (int c = 0; c < 32; c++) begin
      word_len = c[1:0]; parity_on = c[2]; parity_even = c[3]; two_stop = c[4];
      for (int k = 0; k < 2; k++) begin
        logic [7:0] d;
        d = (k == 0) ? 8'(c * 37 + 5) : ~8'(c * 11 + 3);
        put(d);
        recv(d, 1'b1);
      end
    end

    // R5 R6 R8 fill the 16-entry store with no ticks
    tick16 = 1'b0; word_len = 2'd3; parity_on = 1'b0; two_stop = 1'b0;
    queue_on = 1'b1;
    for (int n = 1; n <= 17; n++) begin
      put(8'(8'h40 + n));
      check($sformatf("R8 irq level after %0d writes", n), int'(tx_irq), int'(n - 1 <= 8));
      check($sformatf("R5 full after %0d writes", n), int'(tx_full), int'(n == 17));
    end
    check("R6 ready low when full", int'(wr_ready), 0);
    put(8'hEE);
    check("R6 still full after dropped write", int'(tx_full), 1);
    irq_on = 1'b0;
    @(negedge clk);
    check("R8 irq masked", int'(tx_irq), 0);
    irq_on = 1'b1;
    tick16 = 1'b1;
    for (int n = 1; n <= 17; n++) recv(8'(8'h40 + n), 1'b0);
    repeat (40) @(negedge clk);
    check("R6 dropped byte not sent", int'(tx_busy), 0);
    check("R7 empty after drain", int'(tx_empty), 1);

    // R5 R8 single holding register mode
    tick16 = 1'b0; queue_on = 1'b0;
    put(8'h9A);
    check("R7 empty with frame loaded", int'(tx_empty), 1);
    check("R8 irq single empty", int'(tx_irq), 1);
    put(8'h5B);
    check("R5 single full", int'(tx_full), 1);
    check("R8 irq single held", int'(tx_irq), 0);
    check("R6 ready single", int'(wr_ready), 0);
    put(8'hC3);
    tick16 = 1'b1;
    recv(8'h9A, 1'b0);
    recv(8'h5B, 1'b0);
    repeat (40) @(negedge clk);
    check("R6 single dropped byte", int'(tx_busy), 0);

    // R9 break
    brk = 1'b1;
    @(negedge clk);
    check("R9 break idle low", int'(txd), 0);
    check("R9 break no busy", int'(tx_busy), 0);
    brk = 1'b0;
    @(negedge clk);
    check("R9 break released", int'(txd), 1);
    put(8'hFF);
    brk = 1'b1;
    repeat (20) begin
      @(negedge clk);
      check("R9 break mid-frame", int'(txd), 0);
    end
    check("R9 shifter keeps running", int'(tx_busy), 1);
    brk = 1'b0;
    @(negedge clk);
    check("R9 line follows shifter (data bit 1)", int'(txd), 1);
    repeat (200) @(negedge clk);
    check("R9 frame completed", int'(tx_busy), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule